// File: doc/BRIEF.md
# Descriptor Job Ring Controller

This block controls one channel of a descriptor-driven offload engine. Each channel has an inbound ring and an outbound ring. Both hold fixed-size job descriptors in memory, and the rings share one power-of-two size. Host software owns the rings through a small word-addressed register file. It programs each ring base as a high word and a low word, selects the ring size, and enables the channel with a command write. Ownership then passes in both directions through count-based doorbells. The host reads how many inbound slots are free and writes how many jobs it has just placed there. In the other direction, it reads how many finished entries wait in the outbound ring and writes how many of them it has consumed.

The controller hands each inbound slot address to the execution unit, in ring order, through a valid/ready pair. Each done pulse from the unit completes the oldest job still in flight. For that job, the controller issues one write strobe that puts the job's descriptor address into the next outbound slot. Completions are therefore posted in strict submission order, and each outbound entry carries the address of the inbound entry that produced it. When the outbound ring is full, the done input is refused, which holds back the execution unit.

An interrupt line follows a two-bit status register. One bit records completions, gated by a programmable coalescing threshold. The other bit records doorbell errors, and their cause is kept in a sticky error register.

Top module: `job_ring_ctrl`

## Requirements
- R1: After reset the channel is disabled. The ring-size field (offset 4) reads MAX_LOG2. The free-slot count (offset 5) reads 2^MAX_LOG2. The outbound fill count (offset 7), interrupt status (offset 9) and error register (offset 10) read 0. `job_valid_o` and `irq_o` are low.
- R2: The free-slot count equals the ring size minus the jobs that are pending plus the jobs in flight. A write of n to the add doorbell (offset 6), with n not above the free count, adds n pending jobs. The free count read in the next cycle is n lower. A slot becomes free again when its job completes.
- R3: If the add doorbell value exceeds the free count, only the free count is added and the excess is dropped. Error bit 0 (add overflow) and interrupt status bit 1 (error) are both set.
- R4: Pending jobs are offered on `job_addr_o` in ring order. The address is inbound base + index * 2^DESC_SHIFT, and the index wraps modulo the ring size 2^k, where k is the ring-size field. The base is {high word at offset 0, low word at offset 1}.
- R5: Jobs are offered only while command bit 0 (offset 11) is 1. A write of 0 stops dispatch.
- R6: For each accepted done pulse, `post_valid_o` is high for one cycle in the following cycle. `post_data_o` is the oldest in-flight job address, and `post_addr_o` is outbound base + tail * 2^DESC_SHIFT. The outbound base is {offset 2, offset 3}. The tail wraps with the ring size, and the outbound fill count rises by one.
- R7: While the outbound fill count equals the ring size, `done_ready_o` is low and `done_i` is ignored.
- R8: A write of n to the remove doorbell (offset 8) lowers the outbound fill count by n. A value above the count clears it to zero and sets error bit 1 (remove overflow) and interrupt status bit 1.
- R9: Interrupt status bit 0 is set on every Nth accepted completion, where N is the coalescing field (offset 12); N = 0 acts as 1. A write to that field restarts the count.
- R10: Interrupt status and the error register are write-one-to-clear. A set event in the same cycle wins over the clear. `irq_o` is high whenever any interrupt status bit is set.
- R11: Ring-size writes are ignored while the channel is enabled. Values above MAX_LOG2 are stored as MAX_LOG2. An accepted size write resets all ring indices to 0.
- R12: A done pulse with no job in flight is ignored: no post occurs and the fill count does not change. Unlisted offsets and the doorbell offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on offset) |
| job_valid_o | output | 1 | A job address is offered |
| job_ready_i | input | 1 | Execution unit takes the offered job |
| job_addr_o | output | ADDR_W | Inbound slot address of the offered job |
| done_i | input | 1 | Execution unit finished its oldest job |
| done_ready_o | output | 1 | A done pulse can be accepted |
| post_valid_o | output | 1 | Outbound write strobe |
| post_addr_o | output | ADDR_W | Outbound slot address to write |
| post_data_o | output | ADDR_W | Descriptor address written into the slot |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with MAX_LOG2 = 3, so the largest ring has eight slots. With that size, the bench can fill the outbound ring to capacity, overflow both doorbells, and wrap every index within a few dozen cycles. A 4-bit coalescing field makes the threshold boundary easy to reach. Later in the test, the ring is shrunk to four entries at run time, so the masked wrap is exercised at a size below the maximum. A randomized phase then mixes doorbells, stalls and done pulses against the same reference queue.

// File: rtl/jr_pkg.sv
package jr_pkg;
  localparam logic [3:0] REG_IN_BASE_HI  = 4'd0;
  localparam logic [3:0] REG_IN_BASE_LO  = 4'd1;
  localparam logic [3:0] REG_OUT_BASE_HI = 4'd2;
  localparam logic [3:0] REG_OUT_BASE_LO = 4'd3;
  localparam logic [3:0] REG_RING_LOG2   = 4'd4;
  localparam logic [3:0] REG_IN_FREE     = 4'd5;
  localparam logic [3:0] REG_IN_ADD      = 4'd6;
  localparam logic [3:0] REG_OUT_FILL    = 4'd7;
  localparam logic [3:0] REG_OUT_REMOVE  = 4'd8;
  localparam logic [3:0] REG_IRQ_STAT    = 4'd9;
  localparam logic [3:0] REG_ERR_STAT    = 4'd10;
  localparam logic [3:0] REG_CMD         = 4'd11;
  localparam logic [3:0] REG_COALESCE    = 4'd12;

  typedef struct packed {
    logic err;
    logic done;
  } irq_stat_t;

  typedef struct packed {
    logic rmv_over;
    logic add_over;
  } err_stat_t;
endpackage

// File: rtl/jr_ring_ptr.sv
module jr_ring_ptr #(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [IDX_W-1:0] mask_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (clr_i)  idx_q <= '0;
    else if (adv_i)  idx_q <= (idx_q + 1'b1) & mask_i;
  end

  assign idx_o = idx_q;

  // index never escapes the active ring size (R4)
  assert_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q & ~mask_i) == '0);
endmodule

// File: rtl/jr_irq_ctl.sv
module jr_irq_ctl import jr_pkg::*; #(
  parameter int unsigned COAL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_evt_i,
  input  logic              err_evt_i,
  input  logic              thr_wr_i,
  input  logic [COAL_W-1:0] thr_i,
  input  logic              clr_wr_i,
  input  logic [1:0]        clr_mask_i,
  output irq_stat_t         stat_o,
  output logic [COAL_W-1:0] thr_o,
  output logic              irq_o
);
  logic [COAL_W-1:0] thr_q, cnt_q;
  irq_stat_t         stat_q;
  logic [COAL_W:0]   thr_eff, cnt_inc;
  logic              fire;

  assign thr_eff = (thr_q == '0) ? (COAL_W+1)'(1) : {1'b0, thr_q};
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign fire    = done_evt_i && (cnt_inc >= thr_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q  <= COAL_W'(1);
      cnt_q  <= '0;
      stat_q <= '0;
    end else begin
      if (thr_wr_i) thr_q <= thr_i;
      if (thr_wr_i)        cnt_q <= '0;
      else if (fire)       cnt_q <= '0;
      else if (done_evt_i) cnt_q <= cnt_inc[COAL_W-1:0];
      stat_q <= (stat_q & ~(clr_wr_i ? irq_stat_t'(clr_mask_i) : irq_stat_t'(2'b00)))
              | irq_stat_t'({err_evt_i, fire});
    end
  end

  assign stat_o = stat_q;
  assign thr_o  = thr_q;
  assign irq_o  = stat_q.err | stat_q.done;

  assert_clr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr_i && clr_mask_i == 2'b11 && !done_evt_i && !err_evt_i) |=> !irq_o);
  assert_err_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_evt_i |=> stat_o.err);
endmodule

// File: rtl/job_ring_ctrl.sv
module job_ring_ctrl import jr_pkg::*; #(
  parameter int unsigned ADDR_W     = 40,
  parameter int unsigned MAX_LOG2   = 4,
  parameter int unsigned DESC_SHIFT = 4,
  parameter int unsigned COAL_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              job_valid_o,
  input  logic              job_ready_i,
  output logic [ADDR_W-1:0] job_addr_o,
  input  logic              done_i,
  output logic              done_ready_o,
  output logic              post_valid_o,
  output logic [ADDR_W-1:0] post_addr_o,
  output logic [ADDR_W-1:0] post_data_o,
  output logic              irq_o
);
  localparam int unsigned IDX_W = MAX_LOG2;
  localparam int unsigned CNT_W = MAX_LOG2 + 1;
  localparam int unsigned LOG_W = $clog2(MAX_LOG2 + 1);
  localparam int unsigned HI_W  = ADDR_W - 32;

  logic [HI_W-1:0]   in_hi_q, out_hi_q;
  logic [31:0]       in_lo_q, out_lo_q;
  logic [LOG_W-1:0]  log2_q;
  logic              en_q;
  logic [CNT_W-1:0]  pend_q, infl_q, fill_q;
  err_stat_t         err_q;

  logic [CNT_W-1:0]  sz, sz_m1, avail, add_eff, rmv_eff;
  logic [IDX_W-1:0]  mask, disp_idx, done_idx, tail_idx;
  logic              wr_add, wr_rmv, wr_size, wr_irq, wr_err, wr_coal;
  logic              add_over, rmv_over, disp, done_acc, size_clr;
  logic [ADDR_W-1:0] in_base, out_base, done_slot, out_slot;
  irq_stat_t         irq_stat;
  logic [COAL_W-1:0] coal_thr;
  logic              post_valid_q;
  logic [ADDR_W-1:0] post_addr_q, post_data_q;

  assign sz    = CNT_W'(1) << log2_q;
  assign sz_m1 = sz - 1'b1;
  assign mask  = sz_m1[IDX_W-1:0];
  assign avail = sz - pend_q - infl_q;

  assign wr_add  = reg_we_i && reg_addr_i == REG_IN_ADD;
  assign wr_rmv  = reg_we_i && reg_addr_i == REG_OUT_REMOVE;
  assign wr_size = reg_we_i && reg_addr_i == REG_RING_LOG2;
  assign wr_irq  = reg_we_i && reg_addr_i == REG_IRQ_STAT;
  assign wr_err  = reg_we_i && reg_addr_i == REG_ERR_STAT;
  assign wr_coal = reg_we_i && reg_addr_i == REG_COALESCE;

  // count doorbells clamp to what the ring can take
  assign add_over = wr_add && (reg_wdata_i > 32'(avail));
  assign add_eff  = !wr_add ? '0 : (add_over ? avail : reg_wdata_i[CNT_W-1:0]);
  assign rmv_over = wr_rmv && (reg_wdata_i > 32'(fill_q));
  assign rmv_eff  = !wr_rmv ? '0 : (rmv_over ? fill_q : reg_wdata_i[CNT_W-1:0]);
  assign size_clr = wr_size && !en_q;

  assign job_valid_o  = en_q && (pend_q != '0);
  assign disp         = job_valid_o && job_ready_i;
  assign done_ready_o = (infl_q != '0) && (fill_q != sz);
  assign done_acc     = done_i && done_ready_o;

  assign in_base   = {in_hi_q, in_lo_q};
  assign out_base  = {out_hi_q, out_lo_q};
  assign job_addr_o = in_base  + (ADDR_W'(disp_idx) << DESC_SHIFT);
  assign done_slot  = in_base  + (ADDR_W'(done_idx) << DESC_SHIFT);
  assign out_slot   = out_base + (ADDR_W'(tail_idx) << DESC_SHIFT);

  jr_ring_ptr #(.IDX_W(IDX_W)) i_disp_ptr (
    .clk_i, .rst_ni, .clr_i(size_clr), .adv_i(disp), .mask_i(mask), .idx_o(disp_idx));
  jr_ring_ptr #(.IDX_W(IDX_W)) i_done_ptr (
    .clk_i, .rst_ni, .clr_i(size_clr), .adv_i(done_acc), .mask_i(mask), .idx_o(done_idx));
  jr_ring_ptr #(.IDX_W(IDX_W)) i_tail_ptr (
    .clk_i, .rst_ni, .clr_i(size_clr), .adv_i(done_acc), .mask_i(mask), .idx_o(tail_idx));

  jr_irq_ctl #(.COAL_W(COAL_W)) i_irq (
    .clk_i, .rst_ni,
    .done_evt_i(done_acc),
    .err_evt_i (add_over | rmv_over),
    .thr_wr_i  (wr_coal),
    .thr_i     (reg_wdata_i[COAL_W-1:0]),
    .clr_wr_i  (wr_irq),
    .clr_mask_i(reg_wdata_i[1:0]),
    .stat_o    (irq_stat),
    .thr_o     (coal_thr),
    .irq_o     (irq_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_hi_q  <= '0;
      in_lo_q  <= '0;
      out_hi_q <= '0;
      out_lo_q <= '0;
      log2_q   <= LOG_W'(MAX_LOG2);
      en_q     <= 1'b0;
      pend_q   <= '0;
      infl_q   <= '0;
      fill_q   <= '0;
      err_q    <= '0;
    end else begin
      if (reg_we_i && reg_addr_i == REG_IN_BASE_HI)  in_hi_q  <= reg_wdata_i[HI_W-1:0];
      if (reg_we_i && reg_addr_i == REG_IN_BASE_LO)  in_lo_q  <= reg_wdata_i;
      if (reg_we_i && reg_addr_i == REG_OUT_BASE_HI) out_hi_q <= reg_wdata_i[HI_W-1:0];
      if (reg_we_i && reg_addr_i == REG_OUT_BASE_LO) out_lo_q <= reg_wdata_i;
      if (reg_we_i && reg_addr_i == REG_CMD)         en_q     <= reg_wdata_i[0];
      if (size_clr)
        log2_q <= (reg_wdata_i > 32'(MAX_LOG2)) ? LOG_W'(MAX_LOG2) : reg_wdata_i[LOG_W-1:0];
      pend_q <= pend_q + add_eff - CNT_W'(disp);
      infl_q <= infl_q + CNT_W'(disp) - CNT_W'(done_acc);
      fill_q <= fill_q + CNT_W'(done_acc) - rmv_eff;
      err_q  <= (err_q & ~(wr_err ? err_stat_t'(reg_wdata_i[1:0]) : err_stat_t'(2'b00)))
              | err_stat_t'({rmv_over, add_over});
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      post_valid_q <= 1'b0;
      post_addr_q  <= '0;
      post_data_q  <= '0;
    end else begin
      post_valid_q <= done_acc;
      if (done_acc) begin
        post_addr_q <= out_slot;
        post_data_q <= done_slot;
      end
    end
  end

  assign post_valid_o = post_valid_q;
  assign post_addr_o  = post_addr_q;
  assign post_data_o  = post_data_q;

  always_comb begin
    unique case (reg_addr_i)
      REG_IN_BASE_HI:  reg_rdata_o = 32'(in_hi_q);
      REG_IN_BASE_LO:  reg_rdata_o = in_lo_q;
      REG_OUT_BASE_HI: reg_rdata_o = 32'(out_hi_q);
      REG_OUT_BASE_LO: reg_rdata_o = out_lo_q;
      REG_RING_LOG2:   reg_rdata_o = 32'(log2_q);
      REG_IN_FREE:     reg_rdata_o = 32'(avail);
      REG_OUT_FILL:    reg_rdata_o = 32'(fill_q);
      REG_IRQ_STAT:    reg_rdata_o = 32'(irq_stat);
      REG_ERR_STAT:    reg_rdata_o = 32'(err_q);
      REG_CMD:         reg_rdata_o = 32'(en_q);
      REG_COALESCE:    reg_rdata_o = 32'(coal_thr);
      default:         reg_rdata_o = '0;
    endcase
  end

  assert_in_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(pend_q) + 32'(infl_q)) <= 32'(sz));
  assert_add_clamp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_over && !done_acc) |=> avail == '0);
  assert_off_no_job_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !job_valid_o);
  assert_post_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_acc |=> post_valid_o);
  assert_full_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_q == sz && !wr_rmv && !size_clr) |=> fill_q == $past(fill_q));
  assert_out_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= sz);
  assert_idle_done_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && infl_q == '0) |=> !post_valid_o);
endmodule

// File: tb/test_job_ring_ctrl.sv
module test_job_ring_ctrl;
  localparam int ADDR_W = 40, MAX_LOG2 = 3, DESC_SHIFT = 4, COAL_W = 4;
  localparam logic [ADDR_W-1:0] IBASE = 40'h12_1000_0000;
  localparam logic [ADDR_W-1:0] OBASE = 40'h34_2000_0000;

  logic clk_i = 0, rst_ni = 0;
  logic reg_we_i = 0, job_ready_i = 0, done_i = 0;
  logic [3:0] reg_addr_i = 0;
  logic [31:0] reg_wdata_i = 0, reg_rdata_o;
  logic job_valid_o, done_ready_o, post_valid_o, irq_o;
  logic [ADDR_W-1:0] job_addr_o, post_addr_o, post_data_o;

  always #5 clk_i = ~clk_i;

  job_ring_ctrl #(.ADDR_W(ADDR_W), .MAX_LOG2(MAX_LOG2), .DESC_SHIFT(DESC_SHIFT),
                  .COAL_W(COAL_W)) i_job_ring_ctrl (.*);

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  // reference model state
  int m_en, m_log2, m_pend, m_infl, m_fill, m_didx, m_tidx, m_thr, m_ccnt, m_irq, m_err;
  logic [31:0] m_ihi, m_ilo, m_ohi, m_olo;
  logic [ADDR_W-1:0] m_q[$];
  bit m_pv;
  logic [ADDR_W-1:0] m_pa, m_pd;

  task automatic chk(bit ok, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] ibase();
    return {m_ihi[7:0], m_ilo};
  endfunction
  function automatic logic [ADDR_W-1:0] obase();
    return {m_ohi[7:0], m_olo};
  endfunction

  function automatic logic [31:0] exp_rd(logic [3:0] a);
    int sz = 1 << m_log2;
    case (a)
      0: return m_ihi & 32'hff;
      1: return m_ilo;
      2: return m_ohi & 32'hff;
      3: return m_olo;
      4: return m_log2;
      5: return sz - m_pend - m_infl;
      7: return m_fill;
      9: return m_irq;
      10: return m_err;
      11: return m_en;
      12: return m_thr;
      default: return 0;
    endcase
  endfunction

  task automatic compare();
    int sz = 1 << m_log2;
    bit jv = (m_en != 0) && m_pend > 0;
    logic [ADDR_W-1:0] ja = ibase() + (ADDR_W'(m_didx) << DESC_SHIFT);
    chk(job_valid_o == jv, "R5 job_valid", job_valid_o, jv);
    if (jv) chk(job_addr_o == ja, "R4 job_addr", job_addr_o, ja);
    chk(done_ready_o == (m_infl > 0 && m_fill < sz), "R7 done_ready",
        done_ready_o, (m_infl > 0 && m_fill < sz));
    chk(post_valid_o == m_pv, "R6 post_valid", post_valid_o, m_pv);
    if (m_pv) begin
      chk(post_addr_o == m_pa, "R6 post_addr", post_addr_o, m_pa);
      chk(post_data_o == m_pd, "R6 post_data", post_data_o, m_pd);
    end
    chk(irq_o == (m_irq != 0), "R10 irq_o", irq_o, m_irq != 0);
    chk(reg_rdata_o == exp_rd(reg_addr_i), "R2 reg read", reg_rdata_o, exp_rd(reg_addr_i));
  endtask

  task automatic model_step();
    int sz = 1 << m_log2;
    int avail = sz - m_pend - m_infl;
    bit disp = (m_en != 0) && m_pend > 0 && job_ready_i;
    bit dacc = done_i && m_infl > 0 && m_fill < sz;
    int add = 0, rmv = 0, iset = 0, iclr = 0, eset = 0, eclr = 0;
    int w = reg_wdata_i;
    int thr_eff = (m_thr == 0) ? 1 : m_thr;
    m_pv = dacc;
    if (dacc) begin
      m_pa = obase() + (ADDR_W'(m_tidx) << DESC_SHIFT);
      m_pd = m_q.pop_front();
      m_tidx = (m_tidx + 1) % sz;
      if (m_ccnt + 1 >= thr_eff) begin iset |= 1; m_ccnt = 0; end
      else m_ccnt++;
    end
    if (disp) begin
      m_q.push_back(ibase() + (ADDR_W'(m_didx) << DESC_SHIFT));
      m_didx = (m_didx + 1) % sz;
    end
    if (reg_we_i) begin
      case (reg_addr_i)
        0: m_ihi = reg_wdata_i & 32'hff;
        1: m_ilo = reg_wdata_i;
        2: m_ohi = reg_wdata_i & 32'hff;
        3: m_olo = reg_wdata_i;
        4: if (m_en == 0) begin
             m_log2 = (reg_wdata_i > MAX_LOG2) ? MAX_LOG2 : int'(reg_wdata_i);
             m_didx = 0; m_tidx = 0;
           end
        6: if (reg_wdata_i > avail) begin add = avail; eset |= 1; iset |= 2; end
           else add = w;
        8: if (reg_wdata_i > m_fill) begin rmv = m_fill; eset |= 2; iset |= 2; end
           else rmv = w;
        9: iclr = reg_wdata_i & 3;
        10: eclr = reg_wdata_i & 3;
        11: m_en = reg_wdata_i[0];
        12: begin m_thr = reg_wdata_i & 15; m_ccnt = 0; end
        default: ;
      endcase
    end
    m_pend += add - int'(disp);
    m_infl += int'(disp) - int'(dacc);
    m_fill += int'(dacc) - rmv;
    m_irq = (m_irq & ~iclr) | iset;
    m_err = (m_err & ~eclr) | eset;
  endtask

  task automatic tick();
    #1;
    compare();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    reg_we_i = 0;
    done_i = 0;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    tick();
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] exp, string what);
    reg_addr_i = a;
    #1;
    chk(reg_rdata_o == exp, what, reg_rdata_o, exp);
    tick();
  endtask

  task automatic run(int n, bit jr, bit dn);
    for (int i = 0; i < n; i++) begin
      job_ready_i = jr;
      done_i = dn;
      tick();
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    m_en = 0; m_log2 = MAX_LOG2; m_pend = 0; m_infl = 0; m_fill = 0;
    m_didx = 0; m_tidx = 0; m_thr = 1; m_ccnt = 0; m_irq = 0; m_err = 0;
    m_ihi = 0; m_ilo = 0; m_ohi = 0; m_olo = 0; m_pv = 0; m_pa = 0; m_pd = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    // R1 reset state
    rd(4, MAX_LOG2, "R1 ring size");
    rd(5, 8, "R1 free slots");
    rd(7, 0, "R1 fill");
    rd(9, 0, "R1 irq stat");
    rd(10, 0, "R1 err stat");
    chk(!job_valid_o && !irq_o, "R1 outputs idle", {job_valid_o, irq_o}, 0);

    // R11 clamp while disabled
    wr(4, 9);
    rd(4, 3, "R11 size clamp");

    wr(0, 32'h12); wr(1, 32'h1000_0000);
    wr(2, 32'h34); wr(3, 32'h2000_0000);

    // R2 add doorbell, R5 disabled holds jobs
    wr(6, 3);
    rd(5, 5, "R2 free after add");
    #1 chk(job_valid_o == 0, "R5 no offer while disabled", job_valid_o, 0);
    wr(11, 1);
    #1 chk(job_addr_o == IBASE, "R4 first slot addr", job_addr_o, IBASE);
    run(4, 1, 0);
    run(3, 1, 1);
    run(1, 1, 0);
    rd(7, 3, "R6 fill after completions");
    rd(5, 8, "R2 slots freed on completion");
    rd(9, 1, "R9 done irq every job");
    wr(9, 1);
    rd(9, 0, "R10 irq W1C");
    wr(8, 3);
    rd(7, 0, "R8 remove");

    // R3 add overflow
    wr(6, 20);
    rd(10, 1, "R3 add overflow flag");
    rd(9, 2, "R3 error irq");
    rd(5, 0, "R3 clamped to free");
    run(14, 1, 1);
    rd(7, 8, "R7 fill at capacity");
    wr(6, 2);
    run(3, 1, 0);
    run(3, 1, 1);
    #1 chk(done_ready_o == 0, "R7 full refuses done", done_ready_o, 0);
    rd(7, 8, "R7 done ignored when full");

    // R8 remove overflow
    wr(8, 20);
    rd(10, 3, "R8 remove overflow flag");
    rd(7, 0, "R8 fill clamped");
    run(2, 1, 1);
    run(1, 1, 0);
    wr(8, 2);
    wr(10, 3);
    rd(10, 0, "R10 err W1C");
    wr(9, 3);
    rd(9, 0, "R10 irq cleared");

    // R9 coalescing
    wr(12, 3);
    wr(6, 4);
    run(5, 1, 0);
    run(2, 1, 1);
    rd(9, 0, "R9 below threshold");
    run(1, 1, 1);
    rd(9, 1, "R9 threshold reached");
    run(1, 1, 1);
    run(1, 1, 0);
    wr(8, 4); wr(9, 3); wr(12, 0);

    // R11 size change rules, R4 wrap with smaller ring
    wr(4, 1);
    rd(4, 3, "R11 size write ignored when enabled");
    wr(11, 0);
    wr(4, 2);
    rd(4, 2, "R11 size accepted when disabled");
    rd(5, 4, "R11 free equals new size");
    wr(11, 1);
    job_ready_i = 0;
    wr(6, 2);
    #1 chk(job_addr_o == IBASE, "R4 index reset by size write", job_addr_o, IBASE);
    run(6, 1, 1);
    wr(8, 2);
    for (int r = 0; r < 5; r++) begin
      wr(6, 3);
      run(6, 1, 1);
      wr(8, 3);
    end

    // R12 done with nothing in flight
    run(3, 1, 1);
    rd(7, 0, "R12 idle done ignored");
    rd(6, 0, "R12 doorbell reads zero");

    // randomized mix
    for (int i = 0; i < 600; i++) begin
      int c = $urandom % 8;
      job_ready_i = $urandom % 2;
      done_i = ($urandom % 3) != 0;
      if (c == 0) begin reg_we_i = 1; reg_addr_i = 6; reg_wdata_i = $urandom % 6; end
      else if (c == 1) begin reg_we_i = 1; reg_addr_i = 8; reg_wdata_i = $urandom % 5; end
      else if (c == 2) begin reg_we_i = 1; reg_addr_i = 9; reg_wdata_i = $urandom % 4; end
      else begin reg_we_i = 0; reg_addr_i = 4'($urandom % 13); end
      tick();
    end
    summary();
  end
endmodule